// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block decides whether a phase-locked loop has settled. It watches the up and down pulses of the loop's phase/frequency detector and samples them with a fast measurement clock. For each reference cycle it takes the width of the active pulse, in measurement-clock ticks, as that cycle's phase error. A filtered lock flag results. To set the flag, a run of sixteen cycles with a small error is needed. To clear it, the block uses a separate threshold set at twice the small one. The flag therefore has hysteresis in both time and magnitude.

The two thresholds are inputs given in ticks. With a 5 ns measurement clock, values of 3 and 6 match 15 ns and 30 ns. A stand-by input forces the flag low and discards any partial run. A 3-bit select drives a test output that shows a constant, the oscillator-stable flag or the lock flag.

Top module: `pll_lock_detect`

## Requirements
- R1: After reset, `lock` is 0. With `tmux_sel` = 000 `test_out` is 0, and with 001 it is 1.
- R2: Each up or down pulse is passed through a two-flop synchroniser. A comparison cycle ends on the falling edge of the synchronised pulse. Its phase error is the number of measurement-clock ticks for which the pulse was high. An error is small when it is strictly below `thr_small`.
- R3: While unlocked, `lock` rises only after sixteen consecutive comparison cycles with a small error. Fifteen such cycles leave it at 0.
- R4: While unlocked, a cycle whose error is equal to or above `thr_small` resets the run of small-error cycles to zero.
- R5: While locked, a cycle whose error is strictly above `thr_large` drops `lock` to 0.
- R6: While locked, a cycle whose error is not above `thr_large` (including values from `thr_small` up to and equal to `thr_large`) keeps `lock` at 1.
- R7: While `standby` is 1, `lock` reads 0 with no delay, the locked state is cleared and the run count is cleared. A comparison that ends during stand-by has no effect.
- R8: `tmux_sel` 010 routes `osc_stable` to `test_out`, and 011 routes the lock flag.
- R9: `tmux_sel` codes 100 to 111 give `test_out` = 0 whatever the lock and oscillator states.
- R10: Up and down pulses count alike. If they overlap, the error is the number of ticks for which either one is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Stand-by mode: forces lock low, clears state |
| pfd_up | input | 1 | Detector up pulse (asynchronous) |
| pfd_dn | input | 1 | Detector down pulse (asynchronous) |
| osc_stable | input | 1 | Reference oscillator stable flag |
| tmux_sel | input | 3 | Test output select |
| thr_small | input | CW | Entry threshold in ticks |
| thr_large | input | CW | Exit threshold in ticks |
| lock | output | 1 | Filtered lock flag |
| test_out | output | 1 | Selected test signal |

## Verification
A comparison can end in the same cycle that `standby` is high. The sharpest case is the sixteenth small-error cycle of a run, which would otherwise set the flag. The bench builds a run of fifteen small-error pulses and then holds `standby` high across the whole sixteenth pulse, including its falling edge. It checks that `lock` stays 0 after `standby` is released. It then checks that fifteen more small cycles still leave the flag low and that a sixteenth sets it, which shows the run was cleared and not merely paused.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;
  // Error counts are compared against thresholds in measurement-clock ticks.
  function automatic logic err_is_small(input logic [15:0] err, input logic [15:0] thr);
    return err < thr;
  endfunction

  function automatic logic err_is_big(input logic [15:0] err, input logic [15:0] thr);
    return err > thr;
  endfunction

  typedef enum logic [2:0] {
    TM_LOW   = 3'b000,
    TM_HIGH  = 3'b001,
    TM_OSC   = 3'b010,
    TM_LOCK  = 3'b011
  } tmux_e;
endpackage

// File: rtl/lockdet_sync.sv
module lockdet_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [STAGES-1:0] chain [W];

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[b] <= '0;
      else        chain[b] <= {chain[b][STAGES-2:0], d_async[b]};
    end
    assign d_sync[b] = chain[b][STAGES-1];
  end
endmodule

// File: rtl/lockdet_meter.sv
module lockdet_meter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pulse,
  output logic          cyc_done,
  output logic [CW-1:0] err_ticks
);
  logic [CW-1:0] width_q;
  logic          pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= pulse;
      if (pulse) width_q <= (&width_q) ? width_q : width_q + 1'b1;
      else       width_q <= '0;
    end
  end

  assign cyc_done  = pulse_q && !pulse;
  assign err_ticks = width_q;

  // R2: a completed measurement always covers at least one tick
  p_nonzero_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |-> (err_ticks != '0));
endmodule

// File: rtl/lockdet_fsm.sv
module lockdet_fsm
  import lockdet_pkg::*;
#(
  parameter int CW      = 8,
  parameter int RUN_LEN = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          standby,
  input  logic          cyc_done,
  input  logic [CW-1:0] err_ticks,
  input  logic [CW-1:0] thr_small,
  input  logic [CW-1:0] thr_large,
  output logic          locked
);
  localparam int RW = $clog2(RUN_LEN);

  logic [RW-1:0] run_q;
  logic          err_small, err_big, run_full;

  assign err_small = err_is_small(16'(err_ticks), 16'(thr_small));
  assign err_big   = err_is_big(16'(err_ticks), 16'(thr_large));
  assign run_full  = (run_q == RW'(RUN_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      run_q  <= '0;
    end else if (standby) begin
      locked <= 1'b0;
      run_q  <= '0;
    end else if (cyc_done) begin
      if (!locked) begin
        if (!err_small)    run_q <= '0;
        else if (run_full) begin
          locked <= 1'b1;
          run_q  <= '0;
        end else           run_q <= run_q + 1'b1;
      end else if (err_big) begin
        locked <= 1'b0;
        run_q  <= '0;
      end
    end
  end

  // R3: lock only rises on a completed comparison
  p_rise_on_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !cyc_done) |=> !locked);
  // R5: a large error while locked drops lock
  p_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !standby && cyc_done && err_big) |=> !locked);
  // R6: nothing but a large error or stand-by drops lock
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !standby && !(cyc_done && err_big)) |=> locked);
  // R7: stand-by leaves the state unlocked
  p_standby_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> !locked);
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect
  import lockdet_pkg::*;
#(
  parameter int CW      = 8,
  parameter int RUN_LEN = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          standby,
  input  logic          pfd_up,
  input  logic          pfd_dn,
  input  logic          osc_stable,
  input  logic [2:0]    tmux_sel,
  input  logic [CW-1:0] thr_small,
  input  logic [CW-1:0] thr_large,
  output logic          lock,
  output logic          test_out
);
  logic [1:0]    pfd_s;
  logic          pulse, cyc_done, locked;
  logic [CW-1:0] err_ticks;

  lockdet_sync #(.W(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async({pfd_dn, pfd_up}), .d_sync(pfd_s));

  assign pulse = |pfd_s;

  lockdet_meter #(.CW(CW)) u_meter (
    .clk(clk), .rst_n(rst_n), .pulse(pulse),
    .cyc_done(cyc_done), .err_ticks(err_ticks));

  lockdet_fsm #(.CW(CW), .RUN_LEN(RUN_LEN)) u_fsm (
    .clk(clk), .rst_n(rst_n), .standby(standby),
    .cyc_done(cyc_done), .err_ticks(err_ticks),
    .thr_small(thr_small), .thr_large(thr_large), .locked(locked));

  assign lock = locked && !standby;

  always_comb begin
    case (tmux_sel)
      TM_LOW:  test_out = 1'b0;
      TM_HIGH: test_out = 1'b1;
      TM_OSC:  test_out = osc_stable;
      TM_LOCK: test_out = lock;
      default: test_out = 1'b0;
    endcase
  end

  // R7: stand-by forces the output low at once
  p_standby_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !lock);
  // R9: upper select codes are quiet
  p_upper_sel_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tmux_sel[2] |-> !test_out);
endmodule

// File: tb/pll_lock_detect_bench.sv
module pll_lock_detect_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       standby = 1'b0;
  logic       pfd_up = 1'b0;
  logic       pfd_dn = 1'b0;
  logic       osc_stable = 1'b0;
  logic [2:0] tmux_sel = 3'b000;
  logic [7:0] thr_small = 8'd3;
  logic [7:0] thr_large = 8'd6;
  logic       lock, test_out;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  pll_lock_detect u_pll_lock_detect (
    .clk(clk), .rst_n(rst_n), .standby(standby), .pfd_up(pfd_up), .pfd_dn(pfd_dn),
    .osc_stable(osc_stable), .tmux_sel(tmux_sel), .thr_small(thr_small),
    .thr_large(thr_large), .lock(lock), .test_out(test_out));

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  // one comparison cycle: a pulse of w ticks on up (dn_sel=0) or down
  task automatic pulse(input int w, input bit dn_sel);
    @(negedge clk);
    if (dn_sel) pfd_dn = 1'b1; else pfd_up = 1'b1;
    repeat (w) @(negedge clk);
    pfd_up = 1'b0; pfd_dn = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulses(input int n, input int w, input bit dn_sel);
    for (int i = 0; i < n; i++) pulse(w, dn_sel);
  endtask

  task automatic t_reset();
    check("R1 lock after reset", lock, 1'b0);
    tmux_sel = 3'b000; #1; check("R1 sel 000", test_out, 1'b0);
    tmux_sel = 3'b001; #1; check("R1 sel 001", test_out, 1'b1);
  endtask

  task automatic t_entry();
    pulses(15, 2, 0);
    check("R3 fifteen small cycles", lock, 1'b0);
    pulse(2, 0);
    check("R3 sixteenth small cycle", lock, 1'b1);
    tmux_sel = 3'b011; #1; check("R8 sel 011 shows lock", test_out, 1'b1);
  endtask

  task automatic t_hold_exit();
    pulse(6, 0); check("R6 error equal to large", lock, 1'b1);
    pulse(3, 0); check("R6 error equal to small", lock, 1'b1);
    pulse(7, 0); check("R5 error above large", lock, 1'b0);
  endtask

  task automatic t_run_reset();
    pulses(10, 2, 0);
    pulse(3, 0);                       // R2: width equal to thr_small is not small
    pulses(15, 1, 0);
    check("R4 run restarted by large cycle", lock, 1'b0);
    pulse(2, 0);
    check("R4 sixteenth after restart", lock, 1'b1);
  endtask

  task automatic t_down_pulses();
    pulse(8, 1); check("R10 down pulse drops lock", lock, 1'b0);
    pulses(5, 1, 1);
    // overlapping up (2 ticks) and down (2 ticks, offset 1): union of 3 ticks
    @(negedge clk); pfd_up = 1'b1;
    @(negedge clk); pfd_dn = 1'b1;
    @(negedge clk); pfd_up = 1'b0;
    @(negedge clk); pfd_dn = 1'b0;
    repeat (6) @(negedge clk);
    pulses(15, 1, 1);
    check("R10 overlap counted as union", lock, 1'b0);
    pulse(1, 1);
    check("R10 down pulses lock", lock, 1'b1);
  endtask

  task automatic t_standby();
    @(negedge clk); standby = 1'b1; #1;
    check("R7 stand-by forces low", lock, 1'b0);
    @(negedge clk); standby = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 locked state cleared", lock, 1'b0);
    pulses(15, 2, 0);
    // sixteenth cycle ends while stand-by is high
    @(negedge clk); standby = 1'b1; pfd_up = 1'b1;
    repeat (2) @(negedge clk); pfd_up = 1'b0;
    repeat (6) @(negedge clk); standby = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 collision keeps lock low", lock, 1'b0);
    pulses(15, 2, 0);
    check("R7 run cleared by stand-by", lock, 1'b0);
    pulse(2, 0);
    check("R7 fresh run locks", lock, 1'b1);
  endtask

  task automatic t_mux();
    tmux_sel = 3'b010; osc_stable = 1'b0; #1;
    check("R8 sel 010 osc low", test_out, 1'b0);
    osc_stable = 1'b1; #1;
    check("R8 sel 010 osc high", test_out, 1'b1);
    for (int s = 4; s < 8; s++) begin
      tmux_sel = 3'(s); #1;
      check("R9 upper code low", test_out, 1'b0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_entry();
    t_hold_exit();
    t_run_reset();
    t_down_pulses();
    t_standby();
    t_mux();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #500000;
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule